// File: doc/BRIEF.md
# Foreground Sprite Pixel Renderer

This block is one foreground sprite unit in a tile-based pixel pipeline. For each screen coordinate it is given, it reports whether its sprite covers that pixel and, if so, the 4-bit palette index of the sprite's pixel there. The result goes to a compositor that picks between layers. The unit keeps a private cache of the sprite's attribute word (position and tile number) and of the sprite's 256 tile pixels. This lets the render path run every cycle without touching shared memory.

The cache is refilled from shared RAM through a simple read port with a request/acknowledge handshake. Refill happens only while the vertical blanking input is high. Once per blanking period the unit first reads the attribute word and then reads the 256 pixels of the selected tile in ascending order. If blanking ends before the refill is complete, the refill pauses and continues at the same word in the next blanking period. The new position and tile number take effect only once every pixel has been copied.

The render path has three register stages: a hit test, a cache read (address in one cycle, data in the next), and an output register. The result appears exactly three clock cycles after the coordinate is presented, whether the pixel is a hit or a miss.

Top module: `spr_fg_render`

## Requirements
- R1: During and right after an active-low synchronous reset, `spr_hit`, `spr_cidx` and `mem_req` are all 0.
- R2: When `vblank` is high and no refill has yet completed in the current blanking period, the unit starts a refill. It reads word `ATTR_ADDR`, then words `TILE_BASE + tile*256 + row*16 + col` for pixel numbers 0 to 255 in ascending order. It performs at most one complete refill per blanking period.
- R3: `mem_req` is high only while `vblank` is high. While a request is waiting for `mem_ack`, `mem_addr` does not change. A word is transferred on a clock edge where `mem_req` and `mem_ack` are both high.
- R4: If `vblank` falls before a refill completes, no request is made while `vblank` is low. In the next blanking period the refill resumes at the first word not yet transferred.
- R5: In the attribute word, bits [8:0] are the sprite's x position, bits [16:9] its y position and bits [26:17] its tile number. All higher bits are ignored. A pixel word's colour index is bits [3:0]; the other bits are ignored.
- R6: No coordinate is reported as a hit until the first refill has completed. A refill's new x, y and tile number take effect only when its last pixel has been transferred.
- R7: A coordinate (px, py) presented with `coord_vld` high is a hit exactly when x <= px < x+16 and y <= py < y+16. These bounds do not wrap.
- R8: On a hit, `spr_cidx` is the cached colour index of pixel number (py-y)*16 + (px-x).
- R9: On a miss, or when `coord_vld` is low, `spr_hit` is 0 and `spr_cidx` is 0.
- R10: `spr_hit` and `spr_cidx` reflect the coordinate presented exactly 3 clock cycles earlier, for hits and misses alike.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel pipeline clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vblank | input | 1 | High during vertical blanking; the only time a refill may run |
| coord_vld | input | 1 | The coordinate on px/py is valid this cycle |
| px | input | 9 | Screen x coordinate |
| py | input | 8 | Screen y coordinate |
| mem_req | output | 1 | Read request to shared RAM |
| mem_addr | output | 20 | Word address of the read request |
| mem_ack | input | 1 | Read acknowledge; `mem_rdata` is valid in the same cycle |
| mem_rdata | input | 32 | Read data from shared RAM |
| spr_hit | output | 1 | The sprite covers the coordinate presented 3 cycles earlier |
| spr_cidx | output | 4 | Palette index of the covered pixel, 0 on a miss |

## Verification
The assertions check on every cycle that requests occur only during blanking, that a pending request keeps its address steady, that a miss always carries a zero colour index, and that a hit is always preceded, three cycles earlier, by a valid coordinate. Some behaviour can only be shown by the bench's scenarios, which sweep every coordinate around the sprite and compare against arithmetic expectations. These include the exact hit rectangle and its edges at the screen limits, the pixel chosen inside the tile, the order of refill addresses, the pause and resume across a short blanking period, and the rule that a new position takes effect only after a complete refill.

// File: rtl/spr_fg_pkg.sv
// Package: spr_fg_pkg
// Shared types for the foreground sprite renderer.
// Assumes: nothing beyond IEEE 1800-2017.
package spr_fg_pkg;

    // Refill sequencer states
    typedef enum logic [1:0] {
        FILL_IDLE = 2'd0,   // waiting for a blanking period
        FILL_ATTR = 2'd1,   // fetching the attribute word
        FILL_PIX  = 2'd2,   // fetching tile pixels
        FILL_DONE = 2'd3    // finished for this blanking period
    } fill_state_e;

endpackage

// File: rtl/spr_cache_fill.sv
// Module: spr_cache_fill
// Copies the sprite attribute word and all tile pixels from shared RAM into
// the private cache, but only while vblank is high. The attribute is held in
// a staging register and moved to the live register only after the last pixel.
// Assumes: mem_rdata is valid in the cycle mem_ack is high, and mem_ack is
// only considered while mem_req is high.
module spr_cache_fill
    import spr_fg_pkg::*;
#(
    parameter int X_W       = 9,
    parameter int Y_W       = 8,
    parameter int TILE_W    = 10,
    parameter int SIDE_LOG2 = 4,
    parameter int CIDX_W    = 4,
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 32,
    parameter int ATTR_ADDR = 'h10,
    parameter int TILE_BASE = 'h40000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    vblank,
    output logic                    mem_req,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic                    mem_ack,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic                    wr_en,
    output logic [2*SIDE_LOG2-1:0]  wr_idx,
    output logic [CIDX_W-1:0]       wr_cidx,
    output logic [X_W-1:0]          live_x,
    output logic [Y_W-1:0]          live_y,
    output logic                    live_ok
);
    localparam int PIX_AW = 2 * SIDE_LOG2;
    localparam int ATTR_W = X_W + Y_W + TILE_W;
    localparam logic [PIX_AW-1:0] PIX_LAST = '1;

    fill_state_e        state;
    logic [PIX_AW-1:0]  cnt;
    logic [X_W-1:0]     stg_x;
    logic [Y_W-1:0]     stg_y;
    logic [TILE_W-1:0]  stg_tile;
    logic               xfer;

    // Attribute bits above the three fields carry nothing for this block
    generate
        if (DATA_W > ATTR_W) begin : g_spare
            logic unused_spare;
            assign unused_spare = ^mem_rdata[DATA_W-1:ATTR_W];
        end
    endgenerate

    // Request only in the fetch states and only during blanking
    always_comb mem_req = vblank && (state == FILL_ATTR || state == FILL_PIX);

    // A word moves when request and acknowledge meet
    always_comb xfer = mem_req && mem_ack;

    // Address of the word currently wanted
    always_comb begin
        if (state == FILL_PIX)
            mem_addr = ADDR_W'(TILE_BASE) + (ADDR_W'(stg_tile) << PIX_AW) + ADDR_W'(cnt);
        else
            mem_addr = ADDR_W'(ATTR_ADDR);
    end

    // Write port into the tile pixel cache
    always_comb begin
        wr_en   = xfer && (state == FILL_PIX);
        wr_idx  = cnt;
        wr_cidx = mem_rdata[CIDX_W-1:0];
    end

    // Refill sequencer with staged and live attribute registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= FILL_IDLE;
            cnt      <= '0;
            stg_x    <= '0;
            stg_y    <= '0;
            stg_tile <= '0;
            live_x   <= '0;
            live_y   <= '0;
            live_ok  <= 1'b0;
        end else begin
            case (state)
                FILL_IDLE: begin
                    if (vblank) state <= FILL_ATTR;
                end
                FILL_ATTR: begin
                    if (xfer) begin
                        stg_x    <= mem_rdata[X_W-1:0];
                        stg_y    <= mem_rdata[X_W+Y_W-1:X_W];
                        stg_tile <= mem_rdata[ATTR_W-1:X_W+Y_W];
                        cnt      <= '0;
                        state    <= FILL_PIX;
                    end
                end
                FILL_PIX: begin
                    if (xfer) begin
                        if (cnt == PIX_LAST) begin
                            live_x  <= stg_x;
                            live_y  <= stg_y;
                            live_ok <= 1'b1;
                            state   <= FILL_DONE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                FILL_DONE: begin
                    if (!vblank) state <= FILL_IDLE;
                end
                default: state <= FILL_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spr_tile_cache.sv
// Module: spr_tile_cache
// Private tile pixel store, with one write port and one registered read port.
// Assumes: a read and a write to the same entry in one cycle return the old
// value; the contents are not reset (the consumer gates the output).
module spr_tile_cache #(
    parameter int AW = 8,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store refill data and return the addressed entry one cycle later
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/spr_hit_stage.sv
// Module: spr_hit_stage
// First pipeline stage: decides whether the live sprite covers the incoming
// coordinate and forms the pixel number inside the tile (row-major).
// Assumes: x+SIDE and y+SIDE are computed one bit wider, so the rectangle
// never wraps around the screen edge.
module spr_hit_stage #(
    parameter int X_W       = 9,
    parameter int Y_W       = 8,
    parameter int SIDE_LOG2 = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    coord_vld,
    input  logic [X_W-1:0]          px,
    input  logic [Y_W-1:0]          py,
    input  logic [X_W-1:0]          live_x,
    input  logic [Y_W-1:0]          live_y,
    input  logic                    live_ok,
    output logic                    s1_hit,
    output logic [2*SIDE_LOG2-1:0]  s1_idx
);
    localparam int SIDE = 1 << SIDE_LOG2;

    logic [X_W:0]          x_end;
    logic [Y_W:0]          y_end;
    logic                  in_x;
    logic                  in_y;
    logic [SIDE_LOG2-1:0]  dx;
    logic [SIDE_LOG2-1:0]  dy;

    // Rectangle test and offset inside the sprite
    always_comb begin
        x_end = {1'b0, live_x} + (X_W+1)'(SIDE);
        y_end = {1'b0, live_y} + (Y_W+1)'(SIDE);
        in_x  = (px >= live_x) && ({1'b0, px} < x_end);
        in_y  = (py >= live_y) && ({1'b0, py} < y_end);
        dx    = SIDE_LOG2'(px - live_x);
        dy    = SIDE_LOG2'(py - live_y);
    end

    // Register the hit flag and the pixel number for the read stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_hit <= 1'b0;
            s1_idx <= '0;
        end else begin
            s1_hit <= coord_vld && live_ok && in_x && in_y;
            s1_idx <= {dy, dx};
        end
    end

endmodule

// File: rtl/spr_fg_render.sv
// Module: spr_fg_render
// One foreground sprite render unit. It takes a screen coordinate and, three
// cycles later, returns a hit flag and the palette index of the sprite pixel
// at that coordinate. Its private cache is refilled from shared RAM during
// vertical blanking.
// Assumes: the shared RAM port obeys request/acknowledge with data valid
// together with the acknowledge; coordinates arrive at most one per cycle.
module spr_fg_render #(
    parameter int X_W       = 9,
    parameter int Y_W       = 8,
    parameter int TILE_W    = 10,
    parameter int SIDE_LOG2 = 4,
    parameter int CIDX_W    = 4,
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 32,
    parameter int ATTR_ADDR = 'h10,
    parameter int TILE_BASE = 'h40000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vblank,
    input  logic              coord_vld,
    input  logic [X_W-1:0]    px,
    input  logic [Y_W-1:0]    py,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              spr_hit,
    output logic [CIDX_W-1:0] spr_cidx
);
    localparam int PIX_AW = 2 * SIDE_LOG2;

    logic               wr_en;
    logic [PIX_AW-1:0]  wr_idx;
    logic [CIDX_W-1:0]  wr_cidx;
    logic [X_W-1:0]     live_x;
    logic [Y_W-1:0]     live_y;
    logic               live_ok;
    logic               s1_hit;
    logic [PIX_AW-1:0]  s1_idx;
    logic               s2_hit;
    logic [CIDX_W-1:0]  rd_cidx;

    spr_cache_fill #(
        .X_W(X_W), .Y_W(Y_W), .TILE_W(TILE_W), .SIDE_LOG2(SIDE_LOG2),
        .CIDX_W(CIDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .ATTR_ADDR(ATTR_ADDR), .TILE_BASE(TILE_BASE)
    ) u_fill (
        .clk(clk), .rst_n(rst_n), .vblank(vblank),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_cidx(wr_cidx),
        .live_x(live_x), .live_y(live_y), .live_ok(live_ok)
    );

    spr_hit_stage #(
        .X_W(X_W), .Y_W(Y_W), .SIDE_LOG2(SIDE_LOG2)
    ) u_hit (
        .clk(clk), .rst_n(rst_n), .coord_vld(coord_vld),
        .px(px), .py(py),
        .live_x(live_x), .live_y(live_y), .live_ok(live_ok),
        .s1_hit(s1_hit), .s1_idx(s1_idx)
    );

    spr_tile_cache #(
        .AW(PIX_AW), .DW(CIDX_W)
    ) u_cache (
        .clk(clk), .we(wr_en), .waddr(wr_idx), .wdata(wr_cidx),
        .raddr(s1_idx), .rdata(rd_cidx)
    );

    // Second stage: carry the hit flag alongside the cache read
    always_ff @(posedge clk) begin
        if (!rst_n) s2_hit <= 1'b0;
        else        s2_hit <= s1_hit;
    end

    // Third stage: output register, colour forced to zero on a miss
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spr_hit  <= 1'b0;
            spr_cidx <= '0;
        end else begin
            spr_hit  <= s2_hit;
            spr_cidx <= s2_hit ? rd_cidx : '0;
        end
    end

endmodule

// File: rtl/spr_fg_render_chk.sv
// Module: spr_fg_render_chk
// Checker with cycle-by-cycle properties at the ports of spr_fg_render;
// attached to every instance by the bind statement below.
module spr_fg_render_chk #(
    parameter int ADDR_W = 20,
    parameter int CIDX_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vblank,
    input logic              coord_vld,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              spr_hit,
    input logic [CIDX_W-1:0] spr_cidx
);

    AST_REQ_IN_BLANKING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> vblank); // R3

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (!mem_req || $stable(mem_addr))); // R3

    AST_MISS_ZERO_COLOUR: assert property (@(posedge clk) disable iff (!rst_n)
        !spr_hit |-> (spr_cidx == '0)); // R9

    AST_HIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        spr_hit |-> $past(coord_vld, 3)); // R10

endmodule

bind spr_fg_render spr_fg_render_chk #(.ADDR_W(ADDR_W), .CIDX_W(CIDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .vblank(vblank), .coord_vld(coord_vld),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .spr_hit(spr_hit), .spr_cidx(spr_cidx)
);

// File: tb/spr_fg_render_test.sv
`timescale 1ns/1ps
// Bench: sweeps coordinates around the sprite at several positions, models
// the shared RAM with wait states, and computes every expectation arithmetically.
module spr_fg_render_test;
    localparam int ATTR_ADDR = 'h10;
    localparam int TILE_BASE = 'h40000;

    logic        clk;
    logic        rst_n;
    logic        vblank;
    logic        coord_vld;
    logic [8:0]  px;
    logic [7:0]  py;
    logic        mem_req;
    logic [19:0] mem_addr;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        spr_hit;
    logic [3:0]  spr_cidx;

    int checks = 0;
    int errors = 0;

    // Attribute currently held in the bench's RAM, and the live copy it expects
    int attr_x, attr_y, attr_tile;
    int live_x, live_y, live_ok;
    logic [3:0] bcache [256];

    // RAM model bookkeeping
    int seq_i = 0, wcnt = 0, acks = 0, done_cnt = 0;
    int addr_err = 0, proto_err = 0;
    bit prev_pend = 0;
    logic [19:0] prev_addr;

    // Pipeline expectation queue
    bit    qv [3];
    bit    qh [3];
    int    qc [3];
    string qt [3];

    spr_fg_render uut (
        .clk(clk), .rst_n(rst_n), .vblank(vblank), .coord_vld(coord_vld),
        .px(px), .py(py), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .spr_hit(spr_hit), .spr_cidx(spr_cidx)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic logic [3:0] tile_color(int tile, int j);
        return 4'((tile * 5 + j * 3 + (j >> 4)) ^ (j >> 6));
    endfunction

    function automatic logic [31:0] ram_word(logic [19:0] a);
        int off;
        if (int'(a) == ATTR_ADDR)
            return {5'b10101, 10'(attr_tile), 8'(attr_y), 9'(attr_x)};
        if (int'(a) >= TILE_BASE) begin
            off = int'(a) - TILE_BASE;
            return {28'hABCDE5A, tile_color(off >> 8, off & 255)};
        end
        return 32'hDEADBEEF;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Shared RAM model: acknowledges after 0..2 wait cycles, checks the order
    always @(negedge clk) begin
        int exp_a;
        #1;
        if (!rst_n) begin
            mem_ack = 1'b0;
            prev_pend = 0;
        end else begin
            if (mem_req && !vblank) proto_err++;
            if (prev_pend && mem_req && mem_addr != prev_addr) proto_err++;
            if (mem_req) begin
                if (wcnt == 0) begin
                    exp_a = (seq_i == 0) ? ATTR_ADDR
                                         : TILE_BASE + attr_tile * 256 + (seq_i - 1);
                    if (int'(mem_addr) != exp_a) addr_err++;
                    mem_ack = 1'b1;
                    mem_rdata = ram_word(mem_addr);
                    if (seq_i > 0) bcache[seq_i - 1] = mem_rdata[3:0];
                    seq_i++;
                    acks++;
                    if (seq_i == 257) begin
                        live_x = attr_x; live_y = attr_y; live_ok = 1;
                        seq_i = 0;
                        done_cnt++;
                    end
                    wcnt = acks % 3;
                    prev_pend = 0;
                end else begin
                    mem_ack = 1'b0;
                    wcnt--;
                    prev_pend = 1;
                    prev_addr = mem_addr;
                end
            end else begin
                mem_ack = 1'b0;
                prev_pend = 0;
            end
        end
    end

    // One coordinate per cycle; compare the result due from 3 cycles earlier
    task automatic step(input bit vld, input int x, input int y, input string tag);
        bit h;
        @(negedge clk);
        if (qv[2]) begin
            chk(spr_hit == qh[2], qt[2], "hit", int'(spr_hit), int'(qh[2]));
            chk(int'(spr_cidx) == qc[2], qt[2], "colour", int'(spr_cidx), qc[2]);
        end
        for (int k = 2; k > 0; k--) begin
            qv[k] = qv[k-1]; qh[k] = qh[k-1]; qc[k] = qc[k-1]; qt[k] = qt[k-1];
        end
        coord_vld = vld;
        px = 9'(x);
        py = 8'(y);
        h = vld && live_ok != 0 && x >= live_x && x < live_x + 16 &&
            y >= live_y && y < live_y + 16;
        qh[0] = h;
        qc[0] = h ? int'(bcache[(y - live_y) * 16 + (x - live_x)]) : 0;
        qv[0] = 1;
        qt[0] = tag;
    endtask

    task automatic drain();
        for (int k = 0; k < 3; k++) step(0, 0, 0, "R9 idle");
        for (int k = 0; k < 3; k++) qv[k] = 0;
    endtask

    task automatic sweep(input bit vld, input int x0, input int x1,
                         input int y0, input int y1, input string tag);
        for (int y = y0; y <= y1; y++)
            for (int x = x0; x <= x1; x++)
                step(vld, x, y, tag);
        drain();
    endtask

    task automatic do_refresh(input int target, input string tag);
        @(negedge clk);
        vblank = 1'b1;
        while (done_cnt < target) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk(mem_req == 1'b0, "R2", "request after refill done", int'(mem_req), 0);
        end
        vblank = 1'b0;
        repeat (2) @(negedge clk);
        chk(addr_err == 0, tag, "refill address order errors", addr_err, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int a0;
        for (int k = 0; k < 3; k++) qv[k] = 0;
        live_x = 0; live_y = 0; live_ok = 0;
        mem_ack = 1'b0; mem_rdata = '0;
        rst_n = 1'b0; vblank = 1'b0; coord_vld = 1'b0; px = '0; py = '0;
        attr_x = 100; attr_y = 50; attr_tile = 5;
        repeat (4) @(negedge clk);
        chk(spr_hit == 1'b0, "R1", "hit in reset", int'(spr_hit), 0);
        chk(mem_req == 1'b0, "R1", "request in reset", int'(mem_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(spr_hit == 1'b0, "R1", "hit after reset", int'(spr_hit), 0);
        chk(spr_cidx == 4'd0, "R1", "colour after reset", int'(spr_cidx), 0);
        chk(mem_req == 1'b0, "R1", "request after reset", int'(mem_req), 0);

        // No refill yet: every coordinate misses
        sweep(1, 96, 120, 46, 70, "R6 before first refill");

        // First refill and full sweep around sprite A
        do_refresh(1, "R2");
        sweep(1, 90, 125, 40, 75, "R5 R7 R8 R10 sprite A");
        sweep(0, 100, 115, 50, 65, "R9 coord_vld low");

        // Sprite B: blanking ends part-way through the refill
        attr_x = 500; attr_y = 240; attr_tile = 1023;
        a0 = acks;
        @(negedge clk);
        vblank = 1'b1;
        while (acks < a0 + 100) @(negedge clk);
        vblank = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk(mem_req == 1'b0, "R4", "request outside blanking", int'(mem_req), 0);
        end
        sweep(1, 96, 120, 46, 70, "R4 R6 old position, mixed pixels");
        do_refresh(2, "R4 resumed refill");
        sweep(1, 488, 511, 232, 255, "R7 R8 right and bottom edge");

        // Sprite C at the origin
        attr_x = 0; attr_y = 0; attr_tile = 'h2A7;
        do_refresh(3, "R2 R5");
        sweep(1, 0, 20, 0, 20, "R7 R8 origin");

        chk(proto_err == 0, "R3", "handshake rule violations", proto_err, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule